// File: doc/BRIEF.md
# Glitch-Free Global Clock Selector

This block picks one of two clock inputs and drives it onto a global clock output. The first input is always the primary clock. The second input is either an alternate clock or a clock made by the fabric logic. A two-bit source code picks which one, and that code may change while the design runs. The low bit of a two-bit select field then chooses between the first and second inputs. All three clocks may be asynchronous to each other.

Each path has an enable chain clocked on the falling edge of its own clock. A path turns on only after its chain has seen the other path turned off. The output is low while a switch is in progress, and no shortened high or low phase reaches it. A power-up reset puts the primary clock on the output at once. A change of the source code while the second input is in use is run as a full switch away and back.

Top module: `gfmux_glitchfree_sel`

## Requirements
- R1: While `pwrup_rst` is high, and right after it falls with `sel[0]`=0, `gclk` carries `clk_a`, whatever the other inputs are.
- R2: With `cfg_src`=2'b00 and `sel[0]`=1, `gclk` carries `clk_alt` once the switch completes.
- R3: With `cfg_src`=2'b01 and `sel[0]`=1, `gclk` carries `clk_fab`. With `sel[0]`=0, it carries `clk_a` for any code.
- R4: Codes 2'b10 and 2'b11 behave like 2'b00: `sel[0]`=1 selects `clk_alt`.
- R5: `sel[1]` has no effect on `gclk` for any code.
- R6: Across any switch, no high or low phase of `gclk` is shorter than the shortest half period of the two clocks involved.
- R7: The two gated paths are never enabled together. During a switch, `gclk` stays low for at least one full period of the new clock.
- R8: A code change while the second input is active disables that path, moves the second input to the new source, and then enables it again, with no runt on `gclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Primary clock, first mux input |
| clk_alt | input | 1 | Alternate clock, second-input candidate |
| clk_fab | input | 1 | Fabric-generated clock, second-input candidate |
| pwrup_rst | input | 1 | Asynchronous power-up reset, active high |
| cfg_src | input | CFG_W | Source code for the second input (01 = fabric clock, others = alternate clock) |
| sel | input | SEL_W | Select field; only bit 0 matters (0 = first input, 1 = second input) |
| gclk | output | 1 | Global clock output |

## Verification
The bench times every high and low phase of `gclk`. A design that dropped the handshake, or gated a clock on its rising edge, would show a short phase at the moment of a switch. The bench also measures the longest low gap around each switch. Letting both enables overlap, or skipping the synchronizer, would shorten that gap below one period of the new clock. The source code is changed from alternate to fabric and back while the second input is active. A design that swapped the second-input mux without first draining that path would either cut a phase short or stay on the old clock. Reset is asserted while the alternate clock is on the output, to show that the primary clock returns at once.

// File: rtl/gfmux_pkg.sv
`timescale 1ns/1ps
package gfmux_pkg;
   typedef enum logic {
      SRC_ALT = 1'b0,
      SRC_FAB = 1'b1
   } alt_src_e;
endpackage

// File: rtl/gfmux_en_chain.sv
`timescale 1ns/1ps
// Falling-edge enable chain: synchronizes a request into its own clock domain.
module gfmux_en_chain #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q,
   output logic busy
);
   logic [STAGES-1:0] st;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(negedge clk or posedge rst) begin
            if (rst) st[i] <= RST_VAL;
            else     st[i] <= d;
         end
      end else begin : g_next
         always_ff @(negedge clk or posedge rst) begin
            if (rst) st[i] <= RST_VAL;
            else     st[i] <= st[i-1];
         end
      end
   end

   assign q    = st[STAGES-1];
   assign busy = |st;
endmodule

// File: rtl/gfmux_src_track.sv
`timescale 1ns/1ps
// Holds the second-input source; moves it only after that path has drained.
module gfmux_src_track
   import gfmux_pkg::*;
#(
   parameter int               CFG_W    = 2,
   parameter logic [CFG_W-1:0] FAB_CODE = 'b01,
   parameter int               STAGES   = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CFG_W-1:0] cfg,
   input  logic             b_busy,
   output alt_src_e         b_src,
   output logic             match
);
   localparam int MM_W = STAGES + 1;

   logic              want;
   logic [STAGES-1:0] want_s;
   logic [STAGES-1:0] busy_s;
   logic [MM_W-1:0]   mm_q;
   alt_src_e          want_e;
   logic              move;

   assign want   = (cfg == FAB_CODE);
   assign want_e = alt_src_e'(want_s[STAGES-1]);
   assign match  = (want_e == b_src);
   assign move   = (&mm_q) && !busy_s[STAGES-1];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         want_s <= '0;
         busy_s <= '0;
         mm_q   <= '0;
         b_src  <= SRC_ALT;
      end else begin
         want_s <= {want_s[STAGES-2:0], want};
         busy_s <= {busy_s[STAGES-2:0], b_busy};
         if (move) begin
            mm_q  <= '0;
            b_src <= want_e;
         end else begin
            mm_q  <= {mm_q[MM_W-2:0], !match};
         end
      end
   end
endmodule

// File: rtl/gfmux_glitchfree_sel.sv
`timescale 1ns/1ps
module gfmux_glitchfree_sel
   import gfmux_pkg::*;
#(
   parameter int               CFG_W       = 2,
   parameter int               SEL_W       = 2,
   parameter int               SYNC_STAGES = 2,
   parameter logic [CFG_W-1:0] FAB_CODE    = 'b01
) (
   input  logic             clk_a,
   input  logic             clk_alt,
   input  logic             clk_fab,
   input  logic             pwrup_rst,
   input  logic [CFG_W-1:0] cfg_src,
   input  logic [SEL_W-1:0] sel,
   output logic             gclk
);
   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("SYNC_STAGES must be at least 2");
   end
   if (SEL_W < 2) begin : g_bad_sel
      $error("SEL_W must be at least 2");
   end
   if (CFG_W < 1) begin : g_bad_cfg
      $error("CFG_W must be at least 1");
   end

   logic     pick_b;
   logic     unused_sel;
   logic     en_a, en_b;
   logic     busy_a_unused, busy_b;
   logic     match;
   alt_src_e b_src;
   logic     clk_b;

   assign pick_b     = sel[0];
   assign unused_sel = ^sel[SEL_W-1:1];

   gfmux_src_track #(
      .CFG_W    (CFG_W),
      .FAB_CODE (FAB_CODE),
      .STAGES   (SYNC_STAGES)
   ) u_track (
      .clk    (clk_a),
      .rst    (pwrup_rst),
      .cfg    (cfg_src),
      .b_busy (busy_b),
      .b_src  (b_src),
      .match  (match)
   );

   assign clk_b = (b_src == SRC_FAB) ? clk_fab : clk_alt;

   gfmux_en_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_chain_a (
      .clk  (clk_a),
      .rst  (pwrup_rst),
      .d    (!pick_b && !en_b),
      .q    (en_a),
      .busy (busy_a_unused)
   );

   gfmux_en_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_chain_b (
      .clk  (clk_b),
      .rst  (pwrup_rst),
      .d    (pick_b && match && !en_a),
      .q    (en_b),
      .busy (busy_b)
   );

   assign gclk = (clk_a & en_a) | (clk_b & en_b);
endmodule

// File: rtl/gfmux_chk.sv
`timescale 1ns/1ps
module gfmux_chk (
   input logic clk_a,
   input logic clk_b,
   input logic rst,
   input logic en_a,
   input logic en_b,
   input logic b_src
);
   // R7: paths never both enabled, seen from either domain
   p_one_path_a_r7: assert property (@(posedge clk_a) disable iff (rst)
      !(en_a && en_b));
   p_one_path_b_r7: assert property (@(posedge clk_b) disable iff (rst)
      !(en_a && en_b));
   // R1: primary path owns the output as reset ends
   p_reset_owner_r1: assert property (@(posedge clk_a) disable iff (rst)
      $fell(rst) |-> (en_a && !en_b));
   // R8: second-input source moves only while that path is off
   p_src_move_r8: assert property (@(posedge clk_a) disable iff (rst)
      !$stable(b_src) |-> (!en_b && !$past(en_b)));
endmodule

bind gfmux_glitchfree_sel gfmux_chk u_chk (
   .clk_a (clk_a),
   .clk_b (clk_b),
   .rst   (pwrup_rst),
   .en_a  (en_a),
   .en_b  (en_b),
   .b_src (b_src)
);

// File: tb/sim_gfmux_glitchfree_sel.sv
`timescale 1ns/1ps
module sim_gfmux_glitchfree_sel;
   logic       clk_a = 1'b0, clk_alt = 1'b0, clk_fab = 1'b0;
   logic       pwrup_rst = 1'b1;
   logic [1:0] cfg_src = 2'b00;
   logic [1:0] sel = 2'b01;
   logic       gclk;

   int checks = 0;
   int failures = 0;

   gfmux_glitchfree_sel u0 (
      .clk_a(clk_a), .clk_alt(clk_alt), .clk_fab(clk_fab),
      .pwrup_rst(pwrup_rst), .cfg_src(cfg_src), .sel(sel), .gclk(gclk)
   );

   // 50 MHz primary, alternate 34 ns, fabric 46 ns
   always #10 clk_a = ~clk_a;
   initial begin #3; forever #17 clk_alt = ~clk_alt; end
   initial begin #7; forever #23 clk_fab = ~clk_fab; end

   // phase monitor
   realtime t_rise = 0.0, t_fall = 0.0, max_low = 0.0;
   bit      armed = 1'b0;
   int      runt_hi = 0, runt_lo = 0;
   int      epoch = 0, seen_epoch = 0;

   always @(posedge gclk) begin
      if (epoch != seen_epoch) begin max_low = 0.0; seen_epoch = epoch; end
      if (armed && !pwrup_rst) begin
         if ($realtime - t_fall < 9.9) runt_lo++;
         if ($realtime - t_fall > max_low) max_low = $realtime - t_fall;
      end
      t_rise = $realtime;
   end
   always @(negedge gclk) begin
      if (armed && !pwrup_rst && ($realtime - t_rise < 9.9)) runt_hi++;
      t_fall = $realtime;
   end

   typedef struct packed {
      logic [1:0] cfg;
      logic [1:0] sel;
      int         per;
      int         tag;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{2'b00, 2'b00, 20, 1},  // R1 primary
      '{2'b00, 2'b01, 34, 2},  // R2 alternate
      '{2'b00, 2'b11, 34, 5},  // R5 sel[1] set, stays alternate
      '{2'b00, 2'b10, 20, 5},  // R5 sel[1] set, back to primary
      '{2'b01, 2'b01, 46, 3},  // R3 fabric
      '{2'b01, 2'b00, 20, 3},  // R3 primary with code 01
      '{2'b10, 2'b01, 34, 4},  // R4 code 10 acts as 00
      '{2'b11, 2'b11, 34, 4},  // R4 code 11 acts as 00
      '{2'b01, 2'b11, 46, 8},  // R8 code change while second input active
      '{2'b00, 2'b01, 34, 8}   // R8 and back
   };

   task automatic check_period(input int exp, input int tag);
      realtime t0, t1;
      @(posedge gclk); t0 = $realtime;
      for (int i = 0; i < 3; i++) begin
         @(posedge gclk); t1 = $realtime;
         checks++;
         if ((t1 - t0) - real'(exp) > 0.5 || real'(exp) - (t1 - t0) > 0.5) begin
            failures++;
            $display("FAIL R%0d period: actual=%0.2f expected=%0d", tag, t1 - t0, exp);
         end
         t0 = t1;
      end
   endtask

   initial begin
      int prev;
      int runts;
      // R1: reset state with second input requested
      #300;
      check_period(20, 1);
      sel = 2'b00;
      #53 pwrup_rst = 1'b0;
      #400;
      armed = 1'b1;
      check_period(20, 1);   // R1 after release
      prev = 20;
      for (int v = 0; v < NV; v++) begin
         runts = runt_hi + runt_lo;
         epoch++;
         cfg_src = VECS[v].cfg;
         sel     = VECS[v].sel;
         #1500;
         check_period(VECS[v].per, VECS[v].tag);
         checks++;   // R6: no short phase during this step
         if (runt_hi + runt_lo != runts) begin
            failures++;
            $display("FAIL R6 short phases: actual=%0d expected=0", runt_hi + runt_lo - runts);
         end
         if (VECS[v].per != prev) begin
            checks++;   // R7: low gap of at least one new period
            if (max_low < real'(VECS[v].per)) begin
               failures++;
               $display("FAIL R7 low gap: actual=%0.2f expected>=%0d", max_low, VECS[v].per);
            end
         end
         prev = VECS[v].per;
      end
      // R1: reset while the alternate clock drives the output
      armed = 1'b0;
      pwrup_rst = 1'b1;
      #100;
      check_period(20, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #2000000;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule